// File: doc/BRIEF.md
# Dual-Source Block Lock Register

This block holds the write-protection state for a set of low-address, mid-address and shadow memory blocks. Each block has one lock bit, and one enable bit sits at the top of the register. A memory controller sends its program and erase requests through the block. A request reaches the array only when the block's effective lock is clear. The effective lock is the OR of this register's bit and the matching bit of a second, independently managed lock register. A lock from either source is therefore enough to protect a block.

The set of blocks that exist is fixed by a parameter. A lock bit for a block that does not exist always reads 1, takes no writes and ignores the nonvolatile reset value. During reset, every lock bit for a block that exists loads from a nonvolatile configuration input. An erased configuration gives all ones, so every block is locked. Lock-field writes take effect only while the enable bit is already set. The enable bit itself can be written at any time.

Top module: `blk_lock_reg`

## Requirements
- R1: While `rst_n` is low, the enable bit (`rd_data_o[DATA_W-1]`) is cleared at each rising clock edge, so it reads 0 after reset.
- R2: While `rst_n` is low, each present block's lock bit loads the matching bit of `nv_lock_i` at each rising edge.
- R3: A lock bit whose `BLK_PRESENT` bit is 0 always reads 1, whatever the value of `nv_lock_i` and whatever is written.
- R4: A write (`wr_en_i` high at a rising edge) while the enable bit reads 1 copies `wr_data_i[NBLK-1:0]` into the present lock bits. The new value is readable after that edge.
- R5: A write while the enable bit reads 0 leaves every lock bit unchanged. Any write loads the enable bit from `wr_data_i[DATA_W-1]`.
- R6: The reserved bits `rd_data_o[DATA_W-2:NBLK]` always read 0, and writes to them have no effect.
- R7: `lock_o` equals the register's lock field ORed bit by bit with `sec_lock_i`. This is combinational.
- R8: `pgm_ok_o` equals `pgm_req_i` AND NOT `lock_o`, and `ers_ok_o` equals `ers_req_i` AND NOT `lock_o`. Both are combinational.
- R9: If `nv_lock_i` is all ones during reset, every lock bit and every `lock_o` bit reads 1 after reset.
- R10: The lock field layout is fixed:
  - low-block locks at bits `[N_LOW-1:0]`;
  - mid-block locks at the next `N_MID` bits;
  - shadow-block locks at the next `N_SHD` bits;
  - the enable bit at bit `DATA_W-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; loads the nonvolatile lock values |
| nv_lock_i | input | N_LOW+N_MID+N_SHD | Nonvolatile reset values for the lock bits |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Register write data |
| rd_data_o | output | DATA_W | Register read value |
| sec_lock_i | input | N_LOW+N_MID+N_SHD | Lock bits from the secondary register |
| lock_o | output | N_LOW+N_MID+N_SHD | Effective lock per block |
| pgm_req_i | input | N_LOW+N_MID+N_SHD | Program request per block |
| ers_req_i | input | N_LOW+N_MID+N_SHD | Erase request per block |
| pgm_ok_o | output | N_LOW+N_MID+N_SHD | Program request passed to the array |
| ers_ok_o | output | N_LOW+N_MID+N_SHD | Erase request passed to the array |

## Verification
The assertions check the following on every cycle:
- absent lock bits stay at 1 and reserved bits stay at 0;
- the effective lock matches the OR of the two sources, and no request passes a locked block;
- a write taken while the register is disabled leaves the lock field stable;
- a write taken while it is enabled lands exactly;
- reset loads the nonvolatile values and clears the enable bit.

Only the bench scenarios show the rest:
- the order rule when one write sets the enable bit and the lock field together;
- the erased-configuration case;
- behaviour across long random mixes of writes, resets and secondary-lock patterns.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

   // Which region a lock index belongs to, derived from the field sizes.
   typedef enum logic [1:0] {
      REGION_LOW = 2'd0,
      REGION_MID = 2'd1,
      REGION_SHD = 2'd2
   } lock_region_e;

   function automatic lock_region_e region_of(input int unsigned idx,
                                              input int unsigned n_low,
                                              input int unsigned n_mid);
      if (idx < n_low)              return REGION_LOW;
      else if (idx < n_low + n_mid) return REGION_MID;
      else                          return REGION_SHD;
   endfunction

endpackage

// File: rtl/blk_lock_cell.sv
module blk_lock_cell #(
   parameter bit PRESENT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nv_i,
   input  logic wr_i,
   input  logic d_i,
   output logic q_o
);

   generate
      if (PRESENT) begin : g_present
         logic q_r;
         always_ff @(posedge clk) begin
            if (!rst_n)    q_r <= nv_i;
            else if (wr_i) q_r <= d_i;
         end
         assign q_o = q_r;
      end else begin : g_absent
         // Absent block: locked permanently, no storage.
         logic unused_in;
         assign unused_in = &{1'b0, clk, rst_n, nv_i, wr_i, d_i};
         assign q_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en_i,
   input  logic en_d_i,
   output logic en_o,
   output logic lock_wr_o
);

   logic en_r;

   always_ff @(posedge clk) begin
      if (!rst_n)       en_r <= 1'b0;
      else if (wr_en_i) en_r <= en_d_i;
   end

   // Lock-field writes qualify on the enable value held before this write.
   assign lock_wr_o = wr_en_i & en_r;
   assign en_o      = en_r;

endmodule

// File: rtl/blk_lock_combine.sv
module blk_lock_combine #(
   parameter int unsigned NBLK = 8
) (
   input  logic [NBLK-1:0] own_lock_i,
   input  logic [NBLK-1:0] sec_lock_i,
   input  logic [NBLK-1:0] pgm_req_i,
   input  logic [NBLK-1:0] ers_req_i,
   output logic [NBLK-1:0] lock_o,
   output logic [NBLK-1:0] pgm_ok_o,
   output logic [NBLK-1:0] ers_ok_o
);

   logic [NBLK-1:0] eff;

   generate
      for (genvar i = 0; i < NBLK; i++) begin : g_blk
         assign eff[i]      = own_lock_i[i] | sec_lock_i[i];
         assign pgm_ok_o[i] = pgm_req_i[i] & ~eff[i];
         assign ers_ok_o[i] = ers_req_i[i] & ~eff[i];
      end
   endgenerate

   assign lock_o = eff;

endmodule

// File: rtl/blk_lock_reg.sv
module blk_lock_reg #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned N_LOW  = 8,
   parameter int unsigned N_MID  = 4,
   parameter int unsigned N_SHD  = 2,
   parameter logic [N_LOW+N_MID+N_SHD-1:0] BLK_PRESENT = 14'h17FF
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_LOW+N_MID+N_SHD-1:0] nv_lock_i,
   input  logic                         wr_en_i,
   input  logic [DATA_W-1:0]            wr_data_i,
   output logic [DATA_W-1:0]            rd_data_o,
   input  logic [N_LOW+N_MID+N_SHD-1:0] sec_lock_i,
   output logic [N_LOW+N_MID+N_SHD-1:0] lock_o,
   input  logic [N_LOW+N_MID+N_SHD-1:0] pgm_req_i,
   input  logic [N_LOW+N_MID+N_SHD-1:0] ers_req_i,
   output logic [N_LOW+N_MID+N_SHD-1:0] pgm_ok_o,
   output logic [N_LOW+N_MID+N_SHD-1:0] ers_ok_o
);
   import blk_lock_pkg::*;

   localparam int unsigned NBLK   = N_LOW + N_MID + N_SHD;
   localparam int unsigned EN_POS = DATA_W - 1;
   localparam int unsigned RSV_W  = DATA_W - 1 - NBLK;

   generate
      if (N_LOW == 0 || N_SHD == 0) begin : g_bad_fields
         $error("blk_lock_reg: low and shadow fields need at least one bit");
      end
      if (NBLK + 2 > DATA_W) begin : g_bad_width
         $error("blk_lock_reg: lock fields leave no room for reserved and enable bits");
      end
   endgenerate

   logic            en_q;
   logic            lock_wr;
   logic [NBLK-1:0] lock_q;

   blk_lock_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .en_d_i    (wr_data_i[EN_POS]),
      .en_o      (en_q),
      .lock_wr_o (lock_wr)
   );

   generate
      for (genvar i = 0; i < NBLK; i++) begin : g_lock
         localparam lock_region_e REGION = region_of(i, N_LOW, N_MID);
         if (REGION == REGION_SHD || REGION == REGION_MID || REGION == REGION_LOW) begin : g_cell
            blk_lock_cell #(.PRESENT(BLK_PRESENT[i])) u_cell (
               .clk   (clk),
               .rst_n (rst_n),
               .nv_i  (nv_lock_i[i]),
               .wr_i  (lock_wr),
               .d_i   (wr_data_i[i]),
               .q_o   (lock_q[i])
            );
         end
      end
   endgenerate

   assign rd_data_o = {en_q, {RSV_W{1'b0}}, lock_q};

   blk_lock_combine #(.NBLK(NBLK)) u_comb (
      .own_lock_i (lock_q),
      .sec_lock_i (sec_lock_i),
      .pgm_req_i  (pgm_req_i),
      .ers_req_i  (ers_req_i),
      .lock_o     (lock_o),
      .pgm_ok_o   (pgm_ok_o),
      .ers_ok_o   (ers_ok_o)
   );

endmodule

// File: rtl/blk_lock_reg_chk.sv
module blk_lock_reg_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned N_LOW  = 8,
   parameter int unsigned N_MID  = 4,
   parameter int unsigned N_SHD  = 2,
   parameter logic [N_LOW+N_MID+N_SHD-1:0] BLK_PRESENT = 14'h17FF
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [N_LOW+N_MID+N_SHD-1:0] nv_lock_i,
   input logic                         wr_en_i,
   input logic [DATA_W-1:0]            wr_data_i,
   input logic [DATA_W-1:0]            rd_data_o,
   input logic [N_LOW+N_MID+N_SHD-1:0] sec_lock_i,
   input logic [N_LOW+N_MID+N_SHD-1:0] lock_o,
   input logic [N_LOW+N_MID+N_SHD-1:0] pgm_req_i,
   input logic [N_LOW+N_MID+N_SHD-1:0] ers_req_i,
   input logic [N_LOW+N_MID+N_SHD-1:0] pgm_ok_o,
   input logic [N_LOW+N_MID+N_SHD-1:0] ers_ok_o
);
   localparam int unsigned NBLK   = N_LOW + N_MID + N_SHD;
   localparam int unsigned EN_POS = DATA_W - 1;
   localparam logic [NBLK-1:0] ABSENT = ~BLK_PRESENT;

   logic rst_prev;
   always_ff @(posedge clk) rst_prev <= !rst_n;

   p_en_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_prev |-> !rd_data_o[EN_POS]);

   p_nv_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_prev |-> rd_data_o[NBLK-1:0] == ($past(nv_lock_i) | ABSENT));

   p_absent_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o[NBLK-1:0] & ABSENT) == ABSENT);

   p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && rd_data_o[EN_POS]) |=>
         rd_data_o[NBLK-1:0] == ($past(wr_data_i[NBLK-1:0]) | ABSENT));

   p_disabled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !rd_data_o[EN_POS]) |=> $stable(rd_data_o[NBLK-1:0]));

   p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[DATA_W-2:NBLK] == '0);

   p_or_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o == (rd_data_o[NBLK-1:0] | sec_lock_i));

   p_pgm_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_ok_o & (lock_o | ~pgm_req_i)) == '0);

   p_ers_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ers_ok_o & (lock_o | ~ers_req_i)) == '0);

endmodule

bind blk_lock_reg blk_lock_reg_chk #(
   .DATA_W(DATA_W), .N_LOW(N_LOW), .N_MID(N_MID), .N_SHD(N_SHD),
   .BLK_PRESENT(BLK_PRESENT)
) u_chk (.*);

// File: tb/blk_lock_reg_test.sv
`timescale 1ns/1ps
module blk_lock_reg_test;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned N_LOW  = 8;
   localparam int unsigned N_MID  = 4;
   localparam int unsigned N_SHD  = 2;
   localparam int unsigned NBLK   = N_LOW + N_MID + N_SHD;
   localparam logic [NBLK-1:0] PRES = 14'h17FF;
   localparam logic [NBLK-1:0] ABS  = ~PRES;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NBLK-1:0]   nv_lock = '0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [DATA_W-1:0] rd_data;
   logic [NBLK-1:0]   sec_lock = '0, lock, pgm_req = '0, ers_req = '0, pgm_ok, ers_ok;

   int checks = 0;
   int fails  = 0;

   logic [NBLK-1:0] m_lock;
   logic            m_en;

   always #10 clk = ~clk;

   blk_lock_reg #(.DATA_W(DATA_W), .N_LOW(N_LOW), .N_MID(N_MID), .N_SHD(N_SHD),
                  .BLK_PRESENT(PRES)) uut (
      .clk(clk), .rst_n(rst_n), .nv_lock_i(nv_lock), .wr_en_i(wr_en),
      .wr_data_i(wr_data), .rd_data_o(rd_data), .sec_lock_i(sec_lock),
      .lock_o(lock), .pgm_req_i(pgm_req), .ers_req_i(ers_req),
      .pgm_ok_o(pgm_ok), .ers_ok_o(ers_ok));

   function automatic logic [DATA_W-1:0] exp_rd();
      logic [DATA_W-1:0] v;
      v = '0;
      v[DATA_W-1] = m_en;
      v[NBLK-1:0] = m_lock;
      return v;
   endfunction

   task automatic check(input string req, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [NBLK-1:0] nv);
      nv_lock = nv;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_lock = nv | ABS;
      m_en = 1'b0;
   endtask

   task automatic do_write(input logic we, input logic [DATA_W-1:0] wd, input string req);
      wr_en = we;
      wr_data = wd;
      @(posedge clk);
      if (we) begin
         if (m_en) m_lock = wd[NBLK-1:0] | ABS;
         m_en = wd[DATA_W-1];
      end
      @(negedge clk);
      wr_en = 1'b0;
      check(req, rd_data, exp_rd());
   endtask

   task automatic check_comb(input logic [NBLK-1:0] s, input logic [NBLK-1:0] p,
                             input logic [NBLK-1:0] e);
      logic [NBLK-1:0] eff;
      sec_lock = s; pgm_req = p; ers_req = e;
      #1;
      eff = m_lock | s;
      check("R7 lock_o", {{(DATA_W-NBLK){1'b0}}, lock}, {{(DATA_W-NBLK){1'b0}}, eff});
      check("R8 pgm_ok", {{(DATA_W-NBLK){1'b0}}, pgm_ok}, {{(DATA_W-NBLK){1'b0}}, p & ~eff});
      check("R8 ers_ok", {{(DATA_W-NBLK){1'b0}}, ers_ok}, {{(DATA_W-NBLK){1'b0}}, e & ~eff});
   endtask

   initial begin
      #3_000_000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'hB10C_0042));
      // R1 R2 R3 R6: reset with a cleared configuration
      do_reset('0);
      check("R1 R3 R6 reset state", rd_data, {{(DATA_W-NBLK){1'b0}}, ABS});
      // R2 R10: pattern lands at its field positions
      do_reset(14'h0A5C);
      check("R2 R10 nv pattern", rd_data, 32'h0000_2A5C);
      // R9: erased configuration locks everything
      do_reset('1);
      check("R9 erased", rd_data, 32'h0000_3FFF);
      check_comb('0, '1, '1);
      do_reset('0);
      // R5: lock write while disabled is ignored
      do_write(1'b1, 32'h0000_3FFF, "R5 disabled write");
      // R5: enable bit and lock field together: only enable takes
      do_write(1'b1, 32'h8000_3FFF, "R5 enable with data");
      // R4: enabled write lands; R3 absent bits stay 1
      do_write(1'b1, 32'h8000_1234, "R4 enabled write");
      check("R3 absent after write", {18'b0, rd_data[13], rd_data[11]}, 32'h3);
      do_write(1'b1, 32'h8000_0000, "R3 clear attempt");
      // R6: reserved bits written with ones read 0
      do_write(1'b1, 32'h7FFF_C0FF, "R6 reserved write");
      check_comb(14'h0003, 14'h00FF, 14'h3F0F);
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [DATA_W-1:0] wd;
         if ($urandom_range(0, 60) == 0) begin
            do_reset(NBLK'($urandom));
            check("R2 random reset", rd_data, exp_rd());
         end
         wd = $urandom;
         do_write($urandom_range(0, 2) != 0, wd, m_en ? "R4 random" : "R5 random");
         check_comb(NBLK'($urandom) & NBLK'($urandom), NBLK'($urandom), NBLK'($urandom));
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule